// File: doc/BRIEF.md
# First-Fault Predicate Update Unit

This block keeps the first-fault predicate register of a vector load pipeline: one bit per lane saying whether that lane's data may be trusted after a speculative load. For each load the issue stage presents the load type, the addressing mode and the governing predicate. The memory side then reports access outcomes one lane at a time, in ascending lane order. Each outcome gives a lane number and a fault flag.

For each outcome the unit decides one of four things. It can let the load unit write the lane. It can absorb a fault by clearing the register from the faulting lane upward. It can request a trap. Or it can ignore the outcome. The choice depends on the load type and on whether the faulting lane is the lowest active lane. Software may overwrite the register or set every bit at any time.

Top module: `ffr_unit`

## Requirements
- R1: After reset every register bit is 1, and trap_o, illegal_o and lane_en_o are 0.
- R2: load_kind_i encodes 0 normal, 1 non-faulting, 2 first-faulting and 3 reserved. addr_mode_i encodes 0 scalar+immediate, 1 scalar+scalar, 2 scalar+vector and 3 vector+immediate. A normal load accepts any mode. A non-faulting load accepts only mode 0. A first-faulting load accepts modes 1, 2 and 3. Kind 3 is never accepted. When a start is not accepted, illegal_o is 1 in the cycle after the start, and every outcome up to the next start is ignored.
- R3: In a non-faulting load, a fault on an active lane k clears register bits k up to the top lane, one cycle later. Bits below k keep their values, and no trap is raised.
- R4: In a first-faulting load, a fault on the first active lane (the lowest set predicate bit) raises trap_o one cycle later and leaves the register unchanged.
- R5: In a first-faulting load, a fault on any other active lane is handled as in R3.
- R6: In a normal load, a fault on an active lane raises trap_o one cycle later, and the load never changes the register.
- R7: Once a fault has been absorbed or trapped, every later outcome of the same load is ignored: lane_en_o stays 0, the register does not change and no trap is raised.
- R8: An outcome for an inactive lane (predicate bit 0, or lane number beyond the top lane) is ignored. Such a lane never counts as the first active lane.
- R9: lane_en_o is 1 in the same cycle as a fault-free outcome for an active lane of an accepted load that has not yet seen a fault. Otherwise it is 0.
- R10: sw_setall_i makes every bit 1 at the next edge, and sw_wr_i loads sw_wdata_i at the next edge. Set-all takes priority over write, and write takes priority over a fault clear in the same cycle.
- R11: An outcome presented in the same cycle as start_i is ignored. A start replaces any load still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new load |
| load_kind_i | input | 2 | Load type code (R2) |
| addr_mode_i | input | 2 | Addressing mode code (R2) |
| gov_pred_i | input | LANES | Governing predicate, bit i for lane i |
| lane_vld_i | input | 1 | An access outcome is presented |
| lane_idx_i | input | IDXW | Lane number of the outcome |
| lane_fault_i | input | 1 | The access for that lane faulted |
| sw_wr_i | input | 1 | Software write of the register |
| sw_wdata_i | input | LANES | Value for a software write |
| sw_setall_i | input | 1 | Software set-all command |
| ffr_o | output | LANES | First-fault predicate register |
| trap_o | output | 1 | Trap request, one-cycle pulse |
| illegal_o | output | 1 | Start had a rejected kind/mode pairing, one-cycle pulse |
| lane_en_o | output | 1 | Load unit may write the presented lane |

## Verification
The bench builds the unit with LANES = 8 instead of the default 16. With eight lanes, random predicates place the first active lane at every position many times. Faults then land below, on and above that lane, and every clear boundary from lane 0 to the top lane gets exercised. All sixteen kind/mode pairings also come up often enough that both legal and illegal starts are covered in every combination.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

  typedef enum logic [1:0] {
    LK_NORMAL = 2'd0,
    LK_NOFAULT = 2'd1,
    LK_FIRSTF = 2'd2,
    LK_RSVD = 2'd3
  } load_kind_e;

  typedef enum logic [1:0] {
    AM_SCALAR_IMM = 2'd0,
    AM_SCALAR_SCALAR = 2'd1,
    AM_SCALAR_VEC = 2'd2,
    AM_VEC_IMM = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_CLEAR,
    ACT_TRAP
  } lane_act_e;

  // Accepted pairings of load kind and address mode
  function automatic logic pairing_ok(load_kind_e kind, addr_mode_e mode);
    logic ok;
    unique case (kind)
      LK_NORMAL: ok = 1'b1;
      LK_NOFAULT: ok = (mode == AM_SCALAR_IMM);
      LK_FIRSTF: ok = (mode != AM_SCALAR_IMM);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ffr_first_lane.sv
// Lowest set bit of a predicate; any_o low when no bit is set.
module ffr_first_lane #(
  parameter int LANES = 16,
  localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pred_i,
  output logic [IDXW-1:0]  idx_o,
  output logic             any_o
);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pred_i[i]) begin
        idx_o = IDXW'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ffr_mask_gen.sv
// Mask of the lanes at or above a given lane number.
module ffr_mask_gen #(
  parameter int LANES = 16,
  localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [IDXW-1:0]  lane_i,
  output logic [LANES-1:0] upper_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    assign upper_o[g] = (lane_i <= IDXW'(g));
  end

endmodule

// File: rtl/ffr_lane_ctrl.sv
// Decides what one access outcome does to the load and the register.
module ffr_lane_ctrl
  import ffr_pkg::*;
(
  input  load_kind_e kind_i,
  input  logic       live_i,
  input  logic       vld_i,
  input  logic       active_i,
  input  logic       first_i,
  input  logic       fault_i,
  output lane_act_e  act_o
);

  always_comb begin
    act_o = ACT_NONE;
    if (live_i && vld_i && active_i) begin
      if (!fault_i) begin
        act_o = ACT_WRITE;
      end else begin
        unique case (kind_i)
          LK_NORMAL: act_o = ACT_TRAP;
          LK_NOFAULT: act_o = ACT_CLEAR;
          LK_FIRSTF: act_o = first_i ? ACT_TRAP : ACT_CLEAR;
          default: act_o = ACT_TRAP;
        endcase
      end
    end
  end

endmodule

// File: rtl/ffr_unit.sv
module ffr_unit
  import ffr_pkg::*;
#(
  parameter int LANES = 16,
  localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       load_kind_i,
  input  logic [1:0]       addr_mode_i,
  input  logic [LANES-1:0] gov_pred_i,
  input  logic             lane_vld_i,
  input  logic [IDXW-1:0]  lane_idx_i,
  input  logic             lane_fault_i,
  input  logic             sw_wr_i,
  input  logic [LANES-1:0] sw_wdata_i,
  input  logic             sw_setall_i,
  output logic [LANES-1:0] ffr_o,
  output logic             trap_o,
  output logic             illegal_o,
  output logic             lane_en_o
);

  // reset synchroniser: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // state
  logic [LANES-1:0] ffr_q, ffr_d;
  logic             ffr_en;
  load_kind_e       kind_q;
  logic [LANES-1:0] pred_q;
  logic [IDXW-1:0]  first_q;
  logic             first_vld_q;
  logic             live_q, live_d;
  logic             trap_q, trap_d;
  logic             ill_q, ill_d;

  // decoded start
  load_kind_e  kind_in;
  addr_mode_e  mode_in;
  logic        accept_in;
  logic [IDXW-1:0] first_in;
  logic        first_vld_in;

  assign kind_in   = load_kind_e'(load_kind_i);
  assign mode_in   = addr_mode_e'(addr_mode_i);
  assign accept_in = pairing_ok(kind_in, mode_in);

  ffr_first_lane #(.LANES(LANES)) u_first (
    .pred_i (gov_pred_i),
    .idx_o  (first_in),
    .any_o  (first_vld_in)
  );

  // per-outcome decision
  logic             in_range;
  logic             lane_active;
  logic             lane_first;
  logic [LANES-1:0] upper_mask;
  lane_act_e        act;

  assign in_range    = (int'(lane_idx_i) < LANES);
  assign lane_active = in_range && pred_q[lane_idx_i];
  assign lane_first  = first_vld_q && (lane_idx_i == first_q);

  ffr_lane_ctrl u_ctrl (
    .kind_i   (kind_q),
    .live_i   (live_q && !start_i),
    .vld_i    (lane_vld_i),
    .active_i (lane_active),
    .first_i  (lane_first),
    .fault_i  (lane_fault_i),
    .act_o    (act)
  );

  ffr_mask_gen #(.LANES(LANES)) u_mask (
    .lane_i  (lane_idx_i),
    .upper_o (upper_mask)
  );

  // next state
  always_comb begin
    live_d = live_q;
    trap_d = 1'b0;
    ill_d  = 1'b0;
    if (start_i) begin
      live_d = accept_in;
      ill_d  = !accept_in;
    end else if (act == ACT_TRAP) begin
      live_d = 1'b0;
      trap_d = 1'b1;
    end else if (act == ACT_CLEAR) begin
      live_d = 1'b0;
    end
  end

  always_comb begin
    ffr_en = 1'b1;
    if (sw_setall_i)            ffr_d = '1;
    else if (sw_wr_i)           ffr_d = sw_wdata_i;
    else if (act == ACT_CLEAR)  ffr_d = ffr_q & ~upper_mask;
    else begin
      ffr_d  = ffr_q;
      ffr_en = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ffr_q       <= '1;
      kind_q      <= LK_NORMAL;
      pred_q      <= '0;
      first_q     <= '0;
      first_vld_q <= 1'b0;
      live_q      <= 1'b0;
      trap_q      <= 1'b0;
      ill_q       <= 1'b0;
    end else begin
      if (ffr_en) ffr_q <= ffr_d;
      if (start_i) begin
        kind_q      <= kind_in;
        pred_q      <= gov_pred_i;
        first_q     <= first_in;
        first_vld_q <= first_vld_in;
      end
      live_q <= live_d;
      trap_q <= trap_d;
      ill_q  <= ill_d;
    end
  end

  assign ffr_o     = ffr_q;
  assign trap_o    = trap_q;
  assign illegal_o = ill_q;
  assign lane_en_o = (act == ACT_WRITE);

endmodule

// File: rtl/ffr_unit_chk.sv
module ffr_unit_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             start_i,
  input logic             lane_vld_i,
  input logic             lane_fault_i,
  input logic             sw_wr_i,
  input logic [LANES-1:0] sw_wdata_i,
  input logic             sw_setall_i,
  input logic [1:0]       kind_q,
  input logic [LANES-1:0] ffr_o,
  input logic             trap_o,
  input logic             lane_en_o
);

  // R10
  setall_ones_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    sw_setall_i |=> (ffr_o == '1));

  // R10
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sw_wr_i && !sw_setall_i) |=> (ffr_o == $past(sw_wdata_i)));

  // R3
  no_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!sw_wr_i && !sw_setall_i) |=> ((ffr_o & ~$past(ffr_o)) == '0));

  // R6
  normal_stable_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (kind_q == 2'd0 && !start_i && !sw_wr_i && !sw_setall_i) |=> $stable(ffr_o));

  // R9
  en_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    lane_en_o |-> (lane_vld_i && !lane_fault_i && !start_i));

  // R4
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    trap_o |-> $past(lane_vld_i && lane_fault_i && !start_i));

endmodule

bind ffr_unit ffr_unit_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .start_i      (start_i),
  .lane_vld_i   (lane_vld_i),
  .lane_fault_i (lane_fault_i),
  .sw_wr_i      (sw_wr_i),
  .sw_wdata_i   (sw_wdata_i),
  .sw_setall_i  (sw_setall_i),
  .kind_q       (kind_q),
  .ffr_o        (ffr_o),
  .trap_o       (trap_o),
  .lane_en_o    (lane_en_o)
);

// File: tb/sim_ffr_unit.sv
`timescale 1ns/1ps
module sim_ffr_unit;

  localparam int L = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] load_kind_i = '0, addr_mode_i = '0;
  logic [L-1:0] gov_pred_i = '0;
  logic lane_vld_i = 1'b0;
  logic [IW-1:0] lane_idx_i = '0;
  logic lane_fault_i = 1'b0;
  logic sw_wr_i = 1'b0;
  logic [L-1:0] sw_wdata_i = '0;
  logic sw_setall_i = 1'b0;
  logic [L-1:0] ffr_o;
  logic trap_o, illegal_o, lane_en_o;

  always #2.5 clk = ~clk;

  ffr_unit #(.LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_kind_i(load_kind_i),
    .addr_mode_i(addr_mode_i), .gov_pred_i(gov_pred_i), .lane_vld_i(lane_vld_i),
    .lane_idx_i(lane_idx_i), .lane_fault_i(lane_fault_i), .sw_wr_i(sw_wr_i),
    .sw_wdata_i(sw_wdata_i), .sw_setall_i(sw_setall_i), .ffr_o(ffr_o),
    .trap_o(trap_o), .illegal_o(illegal_o), .lane_en_o(lane_en_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [L-1:0] m_ffr;
  logic [1:0]   m_kind;
  logic [L-1:0] m_pred;
  int           m_first;
  bit           m_live;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input logic [1:0] k, input logic [1:0] md);
    return (k == 2'd0) || (k == 2'd1 && md == 2'd0) || (k == 2'd2 && md != 2'd0);
  endfunction

  function automatic int lowest(input logic [L-1:0] p);
    for (int i = 0; i < L; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [L-1:0] upper(input int ix);
    logic [L-1:0] m;
    for (int i = 0; i < L; i++) m[i] = (i >= ix);
    return m;
  endfunction

  // one clock of stimulus, compared against the reference model
  task automatic cyc(input bit st, input logic [1:0] k, input logic [1:0] md,
                     input logic [L-1:0] pr, input bit v, input int ix, input bit f,
                     input bit wr, input logic [L-1:0] wd, input bit sa, input string tag);
    bit e_en, e_trap, e_ill, do_clr;
    start_i = st; load_kind_i = k; addr_mode_i = md; gov_pred_i = pr;
    lane_vld_i = v; lane_idx_i = IW'(ix); lane_fault_i = f;
    sw_wr_i = wr; sw_wdata_i = wd; sw_setall_i = sa;
    e_en = 0; e_trap = 0; e_ill = 0; do_clr = 0;
    if (!st && v && m_live && ix < L && m_pred[ix]) begin
      if (!f) e_en = 1;
      else if (m_kind == 2'd0) e_trap = 1;
      else if (m_kind == 2'd1) do_clr = 1;
      else if (ix == m_first) e_trap = 1;
      else do_clr = 1;
    end
    #1;
    chk(lane_en_o == e_en, {tag, " R9 lane_en"}, 64'(lane_en_o), 64'(e_en));
    @(posedge clk);
    if (st) begin
      m_kind = k; m_pred = pr; m_first = lowest(pr); m_live = legal(k, md);
      e_ill = !m_live;
    end else if (e_trap || do_clr) begin
      m_live = 0;
    end
    if (sa) m_ffr = '1;
    else if (wr) m_ffr = wd;
    else if (do_clr) m_ffr = m_ffr & ~upper(ix);
    @(negedge clk);
    chk(ffr_o == m_ffr, {tag, " R3 ffr"}, 64'(ffr_o), 64'(m_ffr));
    chk(trap_o == e_trap, {tag, " R4 trap"}, 64'(trap_o), 64'(e_trap));
    chk(illegal_o == e_ill, {tag, " R2 illegal"}, 64'(illegal_o), 64'(e_ill));
    start_i = 0; lane_vld_i = 0; sw_wr_i = 0; sw_setall_i = 0;
  endtask

  task automatic st(input logic [1:0] k, input logic [1:0] md, input logic [L-1:0] pr, input string tag);
    cyc(1, k, md, pr, 0, 0, 0, 0, '0, 0, tag);
  endtask

  task automatic ln(input int ix, input bit f, input string tag);
    cyc(0, 2'd0, 2'd0, '0, 1, ix, f, 0, '0, 0, tag);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    m_ffr = '1; m_kind = '0; m_pred = '0; m_first = -1; m_live = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ffr_o == '1, "R1 ffr", 64'(ffr_o), 64'hff);
    chk(trap_o == 0 && illegal_o == 0 && lane_en_o == 0, "R1 flags",
        64'({trap_o, illegal_o, lane_en_o}), 64'd0);

    // R10 write, set-all, priority
    cyc(0, 0, 0, '0, 0, 0, 0, 1, 8'hA5, 0, "R10 wr");
    chk(ffr_o == 8'hA5, "R10 wr value", 64'(ffr_o), 64'hA5);
    cyc(0, 0, 0, '0, 0, 0, 0, 1, 8'h00, 1, "R10 prio");
    chk(ffr_o == 8'hFF, "R10 setall wins", 64'(ffr_o), 64'hFF);

    // R2 illegal pairing, outcomes ignored afterwards
    st(2'd1, 2'd1, 8'hFF, "R2 nf+ss");
    ln(0, 1, "R2 ignored");
    chk(ffr_o == 8'hFF, "R2 no effect", 64'(ffr_o), 64'hFF);
    st(2'd3, 2'd0, 8'hFF, "R2 rsvd");
    st(2'd2, 2'd0, 8'hFF, "R2 ff+si");

    // R3 non-faulting clear, R7 ignore afterwards
    st(2'd1, 2'd0, 8'hFF, "R3 start");
    ln(0, 0, "R3"); ln(1, 0, "R3"); ln(2, 1, "R3");
    chk(ffr_o == 8'h03, "R3 clear from lane 2", 64'(ffr_o), 64'h03);
    ln(3, 0, "R7"); ln(4, 1, "R7");
    chk(ffr_o == 8'h03 && trap_o == 0, "R7 ignored", 64'(ffr_o), 64'h03);

    // R4 first-faulting trap on first active lane, R8 inactive lane
    cyc(0, 0, 0, '0, 0, 0, 0, 0, '0, 1, "R10 setall");
    st(2'd2, 2'd2, 8'b1111_0100, "R4 start");
    ln(1, 1, "R8 inactive");
    chk(trap_o == 0 && ffr_o == 8'hFF, "R8 no effect", 64'(ffr_o), 64'hFF);
    ln(2, 1, "R4");
    chk(trap_o == 1 && ffr_o == 8'hFF, "R4 trap", 64'({trap_o, ffr_o}), 64'h1FF);

    // R5 first-faulting later lane
    st(2'd2, 2'd3, 8'b0110_1000, "R5 start");
    ln(3, 0, "R5"); ln(5, 1, "R5");
    chk(ffr_o == 8'h1F && trap_o == 0, "R5 clear from lane 5", 64'(ffr_o), 64'h1F);

    // R6 normal load
    st(2'd0, 2'd1, 8'hFF, "R6 start");
    ln(0, 0, "R6"); ln(4, 1, "R6");
    chk(trap_o == 1 && ffr_o == 8'h1F, "R6 trap keep", 64'({trap_o, ffr_o}), 64'h11F);

    // R11 outcome with start ignored; R10 write beats clear
    cyc(1, 2'd1, 2'd0, 8'hFF, 1, 0, 1, 0, '0, 0, "R11 same cycle");
    chk(ffr_o == 8'h1F, "R11 ignored", 64'(ffr_o), 64'h1F);
    cyc(0, 0, 0, '0, 1, 1, 1, 1, 8'hF0, 0, "R10 wr over clear");
    chk(ffr_o == 8'hF0, "R10 write wins", 64'(ffr_o), 64'hF0);

    // random loads
    for (int t = 0; t < 2500; t++) begin
      logic [L-1:0] pr;
      pr = L'($urandom);
      if (($urandom % 8) == 0) cyc(0, 0, 0, '0, 0, 0, 0, ($urandom % 2) == 1, L'($urandom), ($urandom % 2) == 1, "R10 rnd");
      st(2'($urandom), 2'($urandom), pr, "R2 rnd");
      for (int i = 0; i < L; i++) begin
        if (($urandom % 4) != 0)
          ln(i, ($urandom % 6) == 0, "R5 rnd");
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule